// File: doc/BRIEF.md
# Cascadable Configuration Memory Readout Controller

This block is the read side of a small configuration store that streams a bitstream into a programmable device. The device being configured supplies the clock. While the block is selected and not held in reset, each rising clock edge moves an internal position counter forward. The block shows the current element either as one bit on pin 0 (serial mode) or as a whole byte on all eight pins (parallel mode). Each pin has its own tri-state enable.

Once the last element has been read, the block stops counting and gives up the data pins. It then asserts a chain-enable output, which drives the select input of the next store in a cascade, so the two stores behave as one longer memory. The hand-off happens on the clock edge that consumes the last element. On the next cycle the downstream store already shows its first element, and no element is lost or repeated.

The array is a register file with a simple write port for preloading. The reset input doubles as an output enable: holding it low rewinds the stream to position zero and floats the pins.

Top module: `cfg_rom_reader`

## Requirements
- R1: The position counter advances on a rising `clk` edge only when `ce_n` is 0 and `oe_rst_n` is 1 at that edge. When `ce_n` is 1 at an edge, the element on the pins is unchanged once `ce_n` returns low.
- R2: While `oe_rst_n` is 0, `data_oe` is 8'h00. A clock edge with `oe_rst_n` low returns the stream to its first element.
- R3: While `ce_n` is 1, `data_oe` is 8'h00 whatever the level of `oe_rst_n`.
- R4: In serial mode (`par_mode`=0), `data_out[0]` carries the bits of each byte LSB first, bit index 0 to 7, before the byte address increments. An active drive is `data_oe`=8'h01 and the unused pins read 0.
- R5: In parallel mode (`par_mode`=1), `data_out` carries one byte per clock, and an active drive is `data_oe`=8'hFF. Byte 0 is on the pins as soon as `oe_rst_n` and `ce_n` are active, before any clock edge.
- R6: The terminal count is element `DEPTH*8-1` in serial mode and byte `DEPTH-1` in parallel mode. The enabled edge that consumes it marks the store exhausted. From then on, `data_oe` is 8'h00 and further edges do not move the counter.
- R7: When exhausted and `oe_rst_n` is 1, the chain output is active exactly when `ce_n` is 0.
- R8: While `oe_rst_n` is 0, the chain output is at its inactive level. After release, the stream restarts at element 0.
- R9: With `CEO_ACT_HIGH`=0 the chain output's active level is 0. With `CEO_ACT_HIGH`=1 it is 1.
- R10: A clock edge with `wr_en`=1 stores `wr_data` at byte `wr_addr`. That value is what is later read from that byte.
- R11: In a two-store cascade, where the first store's `ceo` drives the second store's `ce_n`, the combined stream is contiguous and the two stores never drive the same pin in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; advances the stream and performs writes |
| oe_rst_n | input | 1 | Low: rewind to element 0 and float the pins; high: enable output |
| ce_n | input | 1 | Active-low select; high puts the block in standby |
| par_mode | input | 1 | 0 serial (one bit per clock on pin 0), 1 parallel (one byte per clock) |
| wr_en | input | 1 | Preload write strobe |
| wr_addr | input | $clog2(DEPTH) | Preload byte address |
| wr_data | input | 8 | Preload byte |
| data_out | output | 8 | Data pins |
| data_oe | output | 8 | Per-pin tri-state enable, 1 = driven |
| ceo | output | 1 | Chain enable for the next store, polarity set by CEO_ACT_HIGH |

## Verification
The embedded properties check on every cycle that:
- standby and reset float the pins;
- the chain output and the data drive are never active together;
- serial mode drives only pin 0 and parallel mode drives all eight;
- a stalled or exhausted counter stays put.

Only the bench scenarios can show the things that depend on data and history: the LSB-first order and byte sequence of the stream, the contiguous hand-off across two cascaded stores, the chain output following `ce_n` after exhaustion, rewind on reset, and the effect of a preload write and of the polarity parameter.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BIDX_W  = 3;

  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } rd_mode_e;

  // pin-drive mask for one active cycle in a given mode
  function automatic logic [BYTE_W-1:0] lane_mask(input rd_mode_e m);
    return (m == MODE_PARALLEL) ? {BYTE_W{1'b1}} : {{(BYTE_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/cfg_mem.sv
module cfg_mem
  import cfg_rom_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_addr] <= wr_data;
  end

  assign rd_data = store_q[rd_addr];
endmodule

// File: rtl/cfg_pos_ctr.sv
module cfg_pos_ctr
  import cfg_rom_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam logic [AW-1:0] LAST_BYTE = AW'(DEPTH - 1)
) (
  input  logic              clk,
  input  logic              oe_rst_n,
  input  logic              ce_n,
  input  rd_mode_e          mode,
  output logic [AW-1:0]     byte_addr,
  output logic [BIDX_W-1:0] bit_idx,
  output logic              exhausted
);
  logic byte_end;
  logic at_tc;
  logic step;

  assign byte_end = (mode == MODE_PARALLEL) || (bit_idx == {BIDX_W{1'b1}});
  assign at_tc    = byte_end && (byte_addr == LAST_BYTE);
  assign step     = !ce_n && !exhausted;

  always_ff @(posedge clk) begin
    if (!oe_rst_n) begin
      byte_addr <= '0;
      bit_idx   <= '0;
      exhausted <= 1'b0;
    end else if (step) begin
      if (at_tc) begin
        exhausted <= 1'b1;
      end else if (byte_end) begin
        byte_addr <= byte_addr + 1'b1;
        bit_idx   <= '0;
      end else begin
        bit_idx   <= bit_idx + 1'b1;
      end
    end
  end

  assert_stall_holds_R1: assert property (@(posedge clk) disable iff (!oe_rst_n)
    ce_n |=> ($stable(byte_addr) && $stable(bit_idx) && $stable(exhausted)));

  assert_exhausted_frozen_R6: assert property (@(posedge clk) disable iff (!oe_rst_n)
    exhausted |=> (exhausted && $stable(byte_addr) && $stable(bit_idx)));
endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage
  import cfg_rom_pkg::*;
#(
  parameter bit CEO_ACT_HIGH = 1'b0
) (
  input  logic              oe_rst_n,
  input  logic              ce_n,
  input  rd_mode_e          mode,
  input  logic              exhausted,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic [BIDX_W-1:0] bit_idx,
  output logic [BYTE_W-1:0] data_out,
  output logic [BYTE_W-1:0] data_oe,
  output logic              ceo
);
  logic selected;
  logic drive;
  logic chain_act;

  assign selected  = oe_rst_n && !ce_n;
  assign drive     = selected && !exhausted;
  assign chain_act = selected && exhausted;

  always_comb begin
    if (mode == MODE_PARALLEL) data_out = rd_byte;
    else                       data_out = {{(BYTE_W-1){1'b0}}, rd_byte[bit_idx]};
  end

  assign data_oe = drive ? lane_mask(mode) : '0;

  generate
    if (CEO_ACT_HIGH) begin : g_ceo_hi
      assign ceo = chain_act;
    end else begin : g_ceo_lo
      assign ceo = !chain_act;
    end
  endgenerate
endmodule

// File: rtl/cfg_rom_reader.sv
module cfg_rom_reader
  import cfg_rom_pkg::*;
#(
  parameter int unsigned DEPTH        = 16,
  parameter bit          CEO_ACT_HIGH = 1'b0,
  localparam int unsigned AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              oe_rst_n,
  input  logic              ce_n,
  input  logic              par_mode,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] data_out,
  output logic [BYTE_W-1:0] data_oe,
  output logic              ceo
);
  rd_mode_e          mode;
  logic [AW-1:0]     byte_addr;
  logic [BIDX_W-1:0] bit_idx;
  logic              exhausted;
  logic [BYTE_W-1:0] rd_byte;
  logic              ceo_active;

  assign mode       = rd_mode_e'(par_mode);
  assign ceo_active = (ceo == CEO_ACT_HIGH);

  cfg_mem #(.DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (byte_addr),
    .rd_data (rd_byte)
  );

  cfg_pos_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk       (clk),
    .oe_rst_n  (oe_rst_n),
    .ce_n      (ce_n),
    .mode      (mode),
    .byte_addr (byte_addr),
    .bit_idx   (bit_idx),
    .exhausted (exhausted)
  );

  cfg_out_stage #(.CEO_ACT_HIGH(CEO_ACT_HIGH)) u_out (
    .oe_rst_n  (oe_rst_n),
    .ce_n      (ce_n),
    .mode      (mode),
    .exhausted (exhausted),
    .rd_byte   (rd_byte),
    .bit_idx   (bit_idx),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .ceo       (ceo)
  );

  // R2 / R8: reset floats the pins and parks the chain output
  always_comb begin
    if (oe_rst_n == 1'b0) begin
      assert_reset_quiet_R2: assert (data_oe == '0 && !ceo_active);
    end
  end

  assert_standby_float_R3: assert property (@(posedge clk) disable iff (!oe_rst_n)
    ce_n |-> (data_oe == '0));

  assert_handoff_exclusive_R6: assert property (@(posedge clk) disable iff (!oe_rst_n)
    ceo_active |-> (data_oe == '0));

  assert_serial_one_pin_R4: assert property (@(posedge clk) disable iff (!oe_rst_n)
    !par_mode |-> (data_oe == '0 || data_oe == 8'h01));

  assert_parallel_all_pins_R5: assert property (@(posedge clk) disable iff (!oe_rst_n)
    par_mode |-> (data_oe == '0 || data_oe == 8'hFF));
endmodule

// File: tb/sim_cfg_rom_reader.sv
module sim_cfg_rom_reader;
  localparam int unsigned NB = 4;
  localparam int unsigned AW = $clog2(NB);
  localparam int unsigned NBITS = NB * 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          oe_rst_n = 1'b0;
  logic          ce0 = 1'b1;
  logic          par = 1'b0;
  logic          we0 = 1'b0, we1 = 1'b0, we2 = 1'b0;
  logic [AW-1:0] wa = '0;
  logic [7:0]    wd = '0;
  logic [7:0]    d0, d1, d2, oe0, oe1, oe2;
  logic          ceo0, ceo1, ceo2;

  cfg_rom_reader #(.DEPTH(NB), .CEO_ACT_HIGH(1'b0)) u0 (
    .clk(clk), .oe_rst_n(oe_rst_n), .ce_n(ce0), .par_mode(par),
    .wr_en(we0), .wr_addr(wa), .wr_data(wd),
    .data_out(d0), .data_oe(oe0), .ceo(ceo0));

  cfg_rom_reader #(.DEPTH(NB), .CEO_ACT_HIGH(1'b0)) u1 (
    .clk(clk), .oe_rst_n(oe_rst_n), .ce_n(ceo0), .par_mode(par),
    .wr_en(we1), .wr_addr(wa), .wr_data(wd),
    .data_out(d1), .data_oe(oe1), .ceo(ceo1));

  cfg_rom_reader #(.DEPTH(NB), .CEO_ACT_HIGH(1'b1)) u2 (
    .clk(clk), .oe_rst_n(oe_rst_n), .ce_n(ce0), .par_mode(par),
    .wr_en(we2), .wr_addr(wa), .wr_data(wd),
    .data_out(d2), .data_oe(oe2), .ceo(ceo2));

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] img0 [NB];
  logic [7:0] img1 [NB];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  function automatic logic [7:0] pat(input int dev, input int idx);
    return 8'((dev * 91 + idx * 55 + 28) ^ (idx << 4));
  endfunction

  function automatic logic exp_bit(input int k);
    if (k < NBITS) return img0[k / 8][k % 8];
    return img1[(k - NBITS) / 8][(k - NBITS) % 8];
  endfunction

  function automatic logic [7:0] exp_byte(input int k);
    if (k < NB) return img0[k];
    return img1[k - NB];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); #1;
    // R10 preload of all three stores while in reset
    for (int i = 0; i < NB; i++) begin
      img0[i] = pat(0, i);
      img1[i] = pat(1, i);
      wa = AW'(i);
      wd = img0[i]; we0 = 1'b1; we2 = 1'b1; step(); we0 = 1'b0; we2 = 1'b0;
      wd = img1[i]; we1 = 1'b1; step(); we1 = 1'b0;
    end
    ce0 = 1'b0; #1;
    chk("R2 reset oe u0", {24'd0, oe0}, 32'h0);
    chk("R2 reset oe u1", {24'd0, oe1}, 32'h0);
    chk("R8 reset ceo u0 inactive", {31'd0, ceo0}, 32'h1);
    chk("R9 reset ceo u2 inactive high-pol", {31'd0, ceo2}, 32'h0);

    // serial cascade sweep, R4 R11 R1
    par = 1'b0;
    oe_rst_n = 1'b1; #1;
    for (int k = 0; k < 2 * NBITS; k++) begin
      if (k == 5 || k == NBITS + 3) begin
        ce0 = 1'b1; #1;
        chk("R3 standby floats u0", {24'd0, oe0}, 32'h0);
        chk("R3 standby floats u1", {24'd0, oe1}, 32'h0);
        step(); step();
        ce0 = 1'b0; #1;
      end
      chk("R11 no contention serial", {24'd0, oe0 & oe1}, 32'h0);
      chk("R4 serial lane mask", {24'd0, oe0 | oe1}, 32'h1);
      chk("R4 serial bit", {31'd0, (oe0[0] & d0[0]) | (oe1[0] & d1[0])}, {31'd0, exp_bit(k)});
      chk("R9 polarity complement", {31'd0, ceo2}, {31'd0, ~ceo0});
      step();
    end
    chk("R6 u0 floats after tc", {24'd0, oe0}, 32'h0);
    chk("R6 u1 floats after tc", {24'd0, oe1}, 32'h0);
    chk("R6 u0 chain active", {31'd0, ceo0}, 32'h0);
    chk("R11 u1 chain active", {31'd0, ceo1}, 32'h0);
    chk("R9 u2 chain active high", {31'd0, ceo2}, 32'h1);
    step(); step(); step();
    chk("R6 stays exhausted", {23'd0, ceo0, oe0 | oe1}, 32'h0);

    // R7 chain follows ce_n after exhaustion
    ce0 = 1'b1; #1;
    chk("R7 ceo follows ce high u0", {31'd0, ceo0}, 32'h1);
    chk("R7 ceo follows ce high u1", {31'd0, ceo1}, 32'h1);
    ce0 = 1'b0; #1;
    chk("R7 ceo follows ce low u0", {31'd0, ceo0}, 32'h0);
    chk("R7 ceo follows ce low u1", {31'd0, ceo1}, 32'h0);

    // R8 reset parks chain output
    oe_rst_n = 1'b0; #1;
    chk("R8 reset ceo u0", {31'd0, ceo0}, 32'h1);
    chk("R8 reset ceo u1", {31'd0, ceo1}, 32'h1);
    chk("R8 reset ceo u2", {31'd0, ceo2}, 32'h0);
    step(); step();
    chk("R2 reset float held", {24'd0, oe0 | oe1}, 32'h0);

    // R10 rewrite byte 0 of u0, then parallel sweep R5
    wa = '0; wd = 8'hA5; we0 = 1'b1; step(); we0 = 1'b0;
    img0[0] = 8'hA5;
    par = 1'b1;
    oe_rst_n = 1'b1; #1;
    chk("R5 first byte before edge", {24'd0, d0}, 32'hA5);
    chk("R10 rewritten byte", {24'd0, oe0 & d0}, 32'hA5);
    for (int k = 0; k < 2 * NB; k++) begin
      if (k == NB + 1) begin
        ce0 = 1'b1; step(); step(); step(); ce0 = 1'b0; #1;
      end
      chk("R11 no contention parallel", {24'd0, oe0 & oe1}, 32'h0);
      chk("R5 parallel lane mask", {24'd0, oe0 | oe1}, 32'hFF);
      chk("R5 parallel byte", {24'd0, (oe0 & d0) | (oe1 & d1)}, {24'd0, exp_byte(k)});
      step();
    end
    chk("R6 parallel exhausted", {23'd0, ceo1, oe0 | oe1}, 32'h0);

    // R2 / R8 rewind mid-stream
    oe_rst_n = 1'b0; step(); oe_rst_n = 1'b1; #1;
    step(); step();
    chk("R1 parallel third byte", {24'd0, d0 & oe0}, {24'd0, img0[2]});
    oe_rst_n = 1'b0; step(); oe_rst_n = 1'b1; #1;
    chk("R2 rewind to first byte", {24'd0, d0 & oe0}, {24'd0, img0[0]});

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule